// File: doc/BRIEF.md
# Register Modification Recovery Logger

This block keeps a short history of the automatic register steps (auto-increment and auto-decrement) that happen while one instruction executes. When an access is aborted part-way through an instruction, fault-recovery software reads the history back and undoes each step before it restarts the instruction.

The history is a 16-bit word made of two byte-wide entries. Each entry packs a signed step amount together with the number of the register that was stepped. A write counter decides which byte takes the next step, so two steps always stay apart, even when they hit the same register. Summing them into one entry would hide the real sequence from the recovery code. An instruction-start strobe empties the history. A freeze level, driven from the error bits of the memory-management status register, holds the history unchanged until software has read it. The word is read through a registered, read-only bus port.

Top module: `regmod_log`

## Requirements
- R1: After synchronous reset both entries, the write counter and `rd_data` are zero.
- R2: An entry holds the register number in bits 2:0 and the step amount in bits 7:3.
- R3: The first accepted update after a clear fills byte 0 (bits 7:0). The second fills byte 1 (bits 15:8).
- R4: Two updates of the same register stay in separate bytes. Two +2 steps of register 7 read back as 16'h1717 (octal 013427), not as a single +4 entry.
- R5: Step amounts are stored in 5-bit two's complement. A -2 step is 5'b11110 and a -1 step is 5'b11111.
- R6: `instr_start` with `freeze` low clears both bytes and the write counter. An update in the same cycle is dropped.
- R7: While `freeze` is high, updates and `instr_start` have no effect: the contents and the write counter are kept.
- R8: Once both bytes are filled, further updates are ignored until the next clear.
- R9: A read strobe `rd_en` loads `rd_data`, at the next edge, with the log word held before that edge. Without a strobe, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | One register step to log this cycle |
| upd_reg | input | 3 | Number of the stepped register |
| upd_delta | input | 5 | Signed step amount, two's complement |
| instr_start | input | 1 | Start of a new instruction, clears the log |
| freeze | input | 1 | Status error present, hold the log |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | 16 | Registered log word |

## Verification
Updates, clears and the freeze take effect at the first clock edge after the driven cycle. A read strobe returns that state one edge later on `rd_data`, showing the word as it stood before the strobe's edge. The driver applies every stimulus for exactly one edge, starting from a falling edge, and queues an expected word for each read. The monitor pops the queue at the falling edge that follows the capture edge, so each comparison sits half a cycle clear of the edge that changed `rd_data`. The hold checks sample `rd_data` directly after a non-read cycle.

// File: rtl/regmod_pkg.sv
package regmod_pkg;
  localparam int unsigned DEF_AMT_W   = 5;
  localparam int unsigned DEF_REG_W   = 3;
  localparam int unsigned DEF_ENTRIES = 2;
endpackage

// File: rtl/regmod_wcount.sv
module regmod_wcount #(
  parameter int unsigned ENTRIES = 2,
  localparam int unsigned CW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          full
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (inc && (cnt_q != CW'(ENTRIES)))
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == CW'(ENTRIES));

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(ENTRIES)); // R8
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/regmod_slot.sv
module regmod_slot #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] q
);
  logic [BW-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst || clr)
      q_r <= '0;
    else if (load)
      q_r <= din;
  end

  assign q = q_r;

  AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q_r == '0)); // R6
  AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load) |=> $stable(q_r)); // R7
endmodule

// File: rtl/regmod_rdport.sv
module regmod_rdport #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic [W-1:0] word,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (rd_en)
      rd_q <= word;
  end

  assign rd_data = rd_q;

  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_q == $past(word))); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q)); // R9
endmodule

// File: rtl/regmod_log.sv
module regmod_log
  import regmod_pkg::*;
#(
  parameter int unsigned AMT_W   = DEF_AMT_W,
  parameter int unsigned REG_W   = DEF_REG_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned BW = AMT_W + REG_W,
  localparam int unsigned LW = BW * ENTRIES,
  localparam int unsigned CW = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [REG_W-1:0] upd_reg,
  input  logic [AMT_W-1:0] upd_delta,
  input  logic             instr_start,
  input  logic             freeze,
  input  logic             rd_en,
  output logic [LW-1:0]    rd_data
);
  logic          clr_eff;
  logic          accept;
  logic          full;
  logic [CW-1:0] cnt;
  logic [BW-1:0] entry_in;
  logic [LW-1:0] log_w;

  assign clr_eff  = instr_start && !freeze;
  assign accept   = upd_valid && !freeze && !instr_start && !full;
  assign entry_in = {upd_delta, upd_reg};

  regmod_wcount #(.ENTRIES(ENTRIES)) u_wcount (
    .clk (clk),
    .rst (rst),
    .clr (clr_eff),
    .inc (accept),
    .cnt (cnt),
    .full(full)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    regmod_slot #(.BW(BW)) u_slot (
      .clk (clk),
      .rst (rst),
      .clr (clr_eff),
      .load(accept && (cnt == CW'(i))),
      .din (entry_in),
      .q   (log_w[i*BW +: BW])
    );
  end

  regmod_rdport #(.W(LW)) u_rdport (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .word   (log_w),
    .rd_data(rd_data)
  );

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(log_w)); // R7
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (full && !clr_eff) |=> $stable(log_w)); // R8
  AST_FIRST_LOW: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && upd_valid && !freeze && !instr_start)
      |=> (log_w[BW-1:0] == {$past(upd_delta), $past(upd_reg)})); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_eff |=> (log_w == '0)); // R6
endmodule

// File: tb/sim_regmod_log.sv
module sim_regmod_log;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [2:0]  upd_reg = '0;
  logic [4:0]  upd_delta = '0;
  logic        instr_start = 1'b0;
  logic        freeze = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  logic        rd_seen = 1'b0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  regmod_log u0 (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_reg(upd_reg),
    .upd_delta(upd_delta), .instr_start(instr_start), .freeze(freeze),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit u, input logic [2:0] r, input logic [4:0] d,
                       input bit s, input bit rd, input logic [15:0] exp, input string tag);
    upd_valid = u; upd_reg = r; upd_delta = d; instr_start = s; rd_en = rd;
    if (rd) begin q_exp.push_back(exp); q_tag.push_back(tag); end
    @(negedge clk);
    upd_valid = 1'b0; instr_start = 1'b0; rd_en = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= rd_en && !rst;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R9: unexpected read result %h expected none", rd_data);
      end else begin
        chk(rd_data, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rd_data, 16'h0000, "R1 reset rd_data");
    drive(0, 0, 0, 0, 1, 16'h0000, "R1 reset log");
    drive(1, 3'd7, 5'd2, 0, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h0017, "R2 R3 first entry low byte");
    drive(1, 3'd7, 5'd2, 0, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h1717, "R4 same register split");
    drive(1, 3'd3, 5'd2, 0, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h1717, "R8 third update ignored");
    drive(0, 0, 0, 1, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h0000, "R6 clear");
    drive(1, 3'd6, 5'b11110, 0, 0, 0, "");
    drive(1, 3'd1, 5'd1, 0, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h09F6, "R5 R3 negative and second");
    freeze = 1'b1;
    drive(0, 0, 0, 1, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h09F6, "R7 clear ignored frozen");
    freeze = 1'b0;
    drive(1, 3'd4, 5'd2, 1, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h0000, "R6 clear wins over update");
    drive(1, 3'd2, 5'b11111, 0, 0, 0, "");
    freeze = 1'b1;
    drive(1, 3'd0, 5'd4, 0, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'h00FA, "R7 update ignored frozen");
    freeze = 1'b0;
    drive(1, 3'd5, 5'b11110, 0, 0, 0, "");
    drive(0, 0, 0, 0, 1, 16'hF5FA, "R7 counter kept R5");
    drive(0, 0, 0, 1, 0, 0, "");
    drive(1, 3'd1, 5'd1, 0, 0, 0, "");
    chk(rd_data, 16'hF5FA, "R9 hold without strobe");
    drive(1, 3'd2, 5'd1, 0, 1, 16'h0009, "R9 read sees word before edge");
    drive(0, 0, 0, 0, 1, 16'h0A09, "R9 read after update");
    repeat (3) @(negedge clk);
    n_chk++;
    if (q_exp.size() != 0) begin
      n_err++;
      $display("FAIL R9: pending reads %0d expected 0", q_exp.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule